// File: doc/BRIEF.md
# Shared-Memory Ownership Handoff Controller

This block sits between a host processor and a hardware accelerator that share one data memory. The host loads scalar arguments and object pointers into a bank of word-wide argument registers, then writes a launch bit. That single write starts the accelerator and hands the shared memory over to it in the same step. From then on the accelerator alone may read and write the memory. The argument registers are frozen so the accelerator sees constant inputs for the whole job.

The host is not halted while the accelerator runs. Register accesses and any other work go on as usual. Only a host request to the shared memory is held back: its ready signal stays low until the accelerator reports completion. When the accelerator finishes, its result word is captured, ownership returns to the host, and a sticky completion flag is raised. The host clears that flag by reading the status word or by launching the next job.

Top module: `hoff_ctrl`

## Requirements
- R1: After reset the host owns the memory (`hmem_ready`=1, `acc_owns`=0), `acc_start` is 0, every argument register reads 0 and the status word reads 0.
- R2: While idle, a host write to word index i (byte offset 4*i, i < N_ARGS) loads argument register i. The register reads back from the same offset and appears on `acc_args[i*DW +: DW]`.
- R3: While the accelerator owns the memory, host writes to argument registers are dropped, and `acc_args` does not change.
- R4: While idle, writing a word with bit 0 set to the control offset (word index N_ARGS, 0x20 by default) produces a one-cycle `acc_start` pulse in the next cycle. In that same cycle `acc_owns` rises and `hmem_ready` falls.
- R5: A launch write while the accelerator already owns the memory produces no `acc_start` pulse and does not change ownership.
- R6: While the accelerator owns the memory, a host memory request sees `hmem_ready`=0. A request the host keeps asserting completes in the first cycle after ownership returns, and its write data is stored.
- R7: Accelerator memory requests act only while `acc_owns`=1. Data the accelerator writes can be read by the host afterwards. An accelerator write made while idle leaves the memory unchanged.
- R8: An `acc_done` pulse while the accelerator owns the memory stores `acc_result` in the result register (word index N_ARGS+2, 0x28 by default). It also clears `acc_owns` and raises `hmem_ready` in the next cycle.
- R9: The status word (word index N_ARGS+1, 0x24 by default) has busy in bit 0 and done in bit 1. Done stays set until a status read returns it or a new launch is accepted, whichever comes first.
- R10: Register reads and shared-memory reads both return their data in the cycle after the access is accepted. Register reads of unmapped or misaligned offsets return 0.
- R11: `hmem_ready` and `acc_owns` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hreg_sel | input | 1 | Host register access strobe |
| hreg_we | input | 1 | Host register write (1) or read (0) |
| hreg_addr | input | REG_AW | Host register byte offset |
| hreg_wdata | input | DW | Host register write data |
| hreg_rdata | output | DW | Host register read data, one cycle after the read |
| hmem_req | input | 1 | Host shared-memory request, held until accepted |
| hmem_we | input | 1 | Host shared-memory write enable |
| hmem_addr | input | MEM_AW | Host shared-memory word address |
| hmem_wdata | input | DW | Host shared-memory write data |
| hmem_ready | output | 1 | Host owns the memory; a request is accepted at the next edge |
| hmem_rdata | output | DW | Shared-memory read data |
| acc_start | output | 1 | One-cycle launch pulse to the accelerator |
| acc_owns | output | 1 | Accelerator currently owns the shared memory |
| acc_args | output | N_ARGS*DW | All argument registers, register i at bits i*DW |
| acc_mem_req | input | 1 | Accelerator shared-memory request |
| acc_mem_we | input | 1 | Accelerator shared-memory write enable |
| acc_mem_addr | input | MEM_AW | Accelerator shared-memory word address |
| acc_mem_wdata | input | DW | Accelerator shared-memory write data |
| acc_mem_rdata | output | DW | Shared-memory read data for the accelerator |
| acc_done | input | 1 | Accelerator completion pulse |
| acc_result | input | DW | Result word, valid with acc_done |

## Verification
The hardest case to reach is a host memory write that arrives while the accelerator owns the memory. The host must hold that write across the accelerator's own traffic and its completion pulse, and the write must then land exactly once. The bench reaches it by forking two threads after a launch. One thread keeps the host request asserted and waits on `hmem_ready`. The other acts as the accelerator: it writes and reads the memory, then pulses `acc_done`. A later host read confirms that both the accelerator's data and the delayed host write are present.

// File: rtl/hoff_pkg.sv
`timescale 1ns/1ps
package hoff_pkg;
  typedef enum logic {
    OWN_HOST = 1'b0,
    OWN_ACC  = 1'b1
  } owner_e;

  typedef struct packed {
    logic done;
    logic busy;
  } stat_t;
endpackage

// File: rtl/hoff_argbank.sv
`timescale 1ns/1ps
module hoff_argbank #(
  parameter int N_ARGS = 8,
  parameter int DW     = 32,
  localparam int IW    = $clog2(N_ARGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic [IW-1:0]        rd_idx,
  output logic [DW-1:0]        rd_data,
  output logic [N_ARGS*DW-1:0] args_flat
);
  logic [DW-1:0] slot [N_ARGS];

  for (genvar i = 0; i < N_ARGS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot[i] <= '0;
      else if (wr_en && (wr_idx == IW'(i)))
        slot[i] <= wr_data;
    end
    assign args_flat[i*DW +: DW] = slot[i];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < N_ARGS; k++)
      if (rd_idx == IW'(k)) rd_data = slot[k];
  end
endmodule

// File: rtl/hoff_own_fsm.sv
`timescale 1ns/1ps
module hoff_own_fsm import hoff_pkg::*; #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch_req,
  input  logic          status_rd,
  input  logic          acc_done,
  input  logic [DW-1:0] acc_result,
  output owner_e        owner,
  output stat_t         stat,
  output logic          start_pulse,
  output logic [DW-1:0] result
);
  logic busy_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      start_pulse <= 1'b0;
      result      <= '0;
    end else begin
      start_pulse <= launch_req && !busy_q;
      if (busy_q) begin
        if (acc_done) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          result <= acc_result;
        end
      end else if (launch_req) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end else if (status_rd) begin
        done_q <= 1'b0;
      end
    end
  end

  assign owner     = busy_q ? OWN_ACC : OWN_HOST;
  assign stat.busy = busy_q;
  assign stat.done = done_q;
endmodule

// File: rtl/hoff_shared_ram.sv
`timescale 1ns/1ps
module hoff_shared_ram #(
  parameter int AW = 8,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (en)
      rdata <= mem[addr];
  end
endmodule

// File: rtl/hoff_ctrl.sv
`timescale 1ns/1ps
module hoff_ctrl import hoff_pkg::*; #(
  parameter int N_ARGS = 8,
  parameter int DW     = 32,
  parameter int MEM_AW = 8,
  parameter int REG_AW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hreg_sel,
  input  logic                 hreg_we,
  input  logic [REG_AW-1:0]    hreg_addr,
  input  logic [DW-1:0]        hreg_wdata,
  output logic [DW-1:0]        hreg_rdata,
  input  logic                 hmem_req,
  input  logic                 hmem_we,
  input  logic [MEM_AW-1:0]    hmem_addr,
  input  logic [DW-1:0]        hmem_wdata,
  output logic                 hmem_ready,
  output logic [DW-1:0]        hmem_rdata,
  output logic                 acc_start,
  output logic                 acc_owns,
  output logic [N_ARGS*DW-1:0] acc_args,
  input  logic                 acc_mem_req,
  input  logic                 acc_mem_we,
  input  logic [MEM_AW-1:0]    acc_mem_addr,
  input  logic [DW-1:0]        acc_mem_wdata,
  output logic [DW-1:0]        acc_mem_rdata,
  input  logic                 acc_done,
  input  logic [DW-1:0]        acc_result
);
  localparam int IW = $clog2(N_ARGS);
  localparam int WW = REG_AW - 2;
  localparam logic [WW-1:0] IDX_CTRL = WW'(N_ARGS);
  localparam logic [WW-1:0] IDX_STAT = WW'(N_ARGS + 1);
  localparam logic [WW-1:0] IDX_RES  = WW'(N_ARGS + 2);

  // register decode
  logic [WW-1:0] widx;
  logic          aligned, hit_arg, hit_ctrl, hit_stat, hit_res;
  logic          reg_wr, reg_rd;

  assign widx     = hreg_addr[REG_AW-1:2];
  assign aligned  = (hreg_addr[1:0] == 2'b00);
  assign hit_arg  = aligned && (widx < IDX_CTRL);
  assign hit_ctrl = aligned && (widx == IDX_CTRL);
  assign hit_stat = aligned && (widx == IDX_STAT);
  assign hit_res  = aligned && (widx == IDX_RES);
  assign reg_wr   = hreg_sel && hreg_we;
  assign reg_rd   = hreg_sel && !hreg_we;

  // ownership and job state
  owner_e        owner;
  stat_t         stat;
  logic          start_pulse;
  logic [DW-1:0] result;
  logic          launch_req, status_rd;

  assign launch_req = reg_wr && hit_ctrl && hreg_wdata[0];
  assign status_rd  = reg_rd && hit_stat;

  hoff_own_fsm #(.DW(DW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .launch_req  (launch_req),
    .status_rd   (status_rd),
    .acc_done    (acc_done),
    .acc_result  (acc_result),
    .owner       (owner),
    .stat        (stat),
    .start_pulse (start_pulse),
    .result      (result)
  );

  // argument bank, frozen while the accelerator owns the memory
  logic [DW-1:0] arg_rd;
  logic          arg_wr_en;

  assign arg_wr_en = reg_wr && hit_arg && (owner == OWN_HOST);

  hoff_argbank #(.N_ARGS(N_ARGS), .DW(DW)) u_args (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (arg_wr_en),
    .wr_idx    (widx[IW-1:0]),
    .wr_data   (hreg_wdata),
    .rd_idx    (widx[IW-1:0]),
    .rd_data   (arg_rd),
    .args_flat (acc_args)
  );

  // register read path
  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (hit_arg)       rd_mux = arg_rd;
    else if (hit_stat) rd_mux = {{(DW-2){1'b0}}, stat.done, stat.busy};
    else if (hit_res)  rd_mux = result;
  end

  always_ff @(posedge clk) begin
    if (rst)
      hreg_rdata <= '0;
    else
      hreg_rdata <= reg_rd ? rd_mux : '0;
  end

  // shared memory, one port steered by the owner
  logic              ram_en, ram_we;
  logic [MEM_AW-1:0] ram_addr;
  logic [DW-1:0]     ram_wdata, ram_q;

  always_comb begin
    if (owner == OWN_ACC) begin
      ram_en    = acc_mem_req;
      ram_we    = acc_mem_we;
      ram_addr  = acc_mem_addr;
      ram_wdata = acc_mem_wdata;
    end else begin
      ram_en    = hmem_req;
      ram_we    = hmem_we;
      ram_addr  = hmem_addr;
      ram_wdata = hmem_wdata;
    end
  end

  hoff_shared_ram #(.AW(MEM_AW), .DW(DW)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_q)
  );

  assign hmem_ready    = (owner == OWN_HOST);
  assign acc_owns      = (owner == OWN_ACC);
  assign hmem_rdata    = ram_q;
  assign acc_mem_rdata = ram_q;
  assign acc_start     = start_pulse;
endmodule

// File: rtl/hoff_ctrl_chk.sv
`timescale 1ns/1ps
module hoff_ctrl_chk #(
  parameter int N_ARGS = 8,
  parameter int DW     = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 hmem_req,
  input logic                 hmem_ready,
  input logic                 acc_owns,
  input logic                 acc_start,
  input logic                 acc_done,
  input logic [N_ARGS*DW-1:0] acc_args
);
  assert_mutex_R11: assert property (@(posedge clk) disable iff (rst)
    !(acc_owns && hmem_ready));

  assert_start_single_R4: assert property (@(posedge clk) disable iff (rst)
    acc_start |=> !acc_start);

  assert_start_grants_R4: assert property (@(posedge clk) disable iff (rst)
    acc_start |-> acc_owns);

  assert_args_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_owns && $past(acc_owns)) |-> $stable(acc_args));

  assert_no_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_owns && $past(acc_owns)) |-> !acc_start);

  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_owns && acc_done) |=> (!acc_owns && hmem_ready));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (hmem_req && !hmem_ready && !acc_done) |=> !hmem_ready);
endmodule

bind hoff_ctrl hoff_ctrl_chk #(.N_ARGS(N_ARGS), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hmem_req   (hmem_req),
  .hmem_ready (hmem_ready),
  .acc_owns   (acc_owns),
  .acc_start  (acc_start),
  .acc_done   (acc_done),
  .acc_args   (acc_args)
);

// File: tb/sim_hoff_ctrl.sv
`timescale 1ns/1ps
module sim_hoff_ctrl;
  localparam int N   = 8;
  localparam int DW  = 32;
  localparam int MAW = 8;
  localparam int RAW = 6;
  localparam logic [RAW-1:0] A_CTRL = 6'h20;
  localparam logic [RAW-1:0] A_STAT = 6'h24;
  localparam logic [RAW-1:0] A_RES  = 6'h28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic           hreg_sel = 0, hreg_we = 0;
  logic [RAW-1:0] hreg_addr = '0;
  logic [DW-1:0]  hreg_wdata = '0, hreg_rdata;
  logic           hmem_req = 0, hmem_we = 0, hmem_ready;
  logic [MAW-1:0] hmem_addr = '0;
  logic [DW-1:0]  hmem_wdata = '0, hmem_rdata;
  logic           acc_start, acc_owns;
  logic [N*DW-1:0] acc_args;
  logic           acc_mem_req = 0, acc_mem_we = 0;
  logic [MAW-1:0] acc_mem_addr = '0;
  logic [DW-1:0]  acc_mem_wdata = '0, acc_mem_rdata;
  logic           acc_done = 0;
  logic [DW-1:0]  acc_result = '0;

  hoff_ctrl u0 (
    .clk(clk), .rst(rst),
    .hreg_sel(hreg_sel), .hreg_we(hreg_we), .hreg_addr(hreg_addr),
    .hreg_wdata(hreg_wdata), .hreg_rdata(hreg_rdata),
    .hmem_req(hmem_req), .hmem_we(hmem_we), .hmem_addr(hmem_addr),
    .hmem_wdata(hmem_wdata), .hmem_ready(hmem_ready), .hmem_rdata(hmem_rdata),
    .acc_start(acc_start), .acc_owns(acc_owns), .acc_args(acc_args),
    .acc_mem_req(acc_mem_req), .acc_mem_we(acc_mem_we), .acc_mem_addr(acc_mem_addr),
    .acc_mem_wdata(acc_mem_wdata), .acc_mem_rdata(acc_mem_rdata),
    .acc_done(acc_done), .acc_result(acc_result)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0] m_args [N];
  logic [DW-1:0] m_mem  [1<<MAW];
  bit            m_busy, m_done, m_start;
  logic [DW-1:0] m_res, m_q, m_rdata;

  initial begin
    for (int i = 0; i < (1<<MAW); i++) m_mem[i] = '0;
  end

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_start = 0;
      m_res = '0; m_q = '0; m_rdata = '0;
      for (int i = 0; i < N; i++) m_args[i] = '0;
    end else begin
      int  idx;
      bit  al, st_rd, go;
      logic [DW-1:0] nrd;
      idx = int'(hreg_addr) / 4;
      al  = (hreg_addr[1:0] == 2'b00);
      nrd = '0;
      if (hreg_sel && !hreg_we && al) begin
        if (idx < N)       nrd = m_args[idx];
        else if (idx == 9) nrd = {30'd0, m_done, m_busy};
        else if (idx == 10) nrd = m_res;
      end
      st_rd = hreg_sel && !hreg_we && al && idx == 9;
      go    = hreg_sel && hreg_we && al && idx == 8 && hreg_wdata[0] && !m_busy;
      if (!m_busy && hmem_req) begin
        m_q = m_mem[hmem_addr];
        if (hmem_we) m_mem[hmem_addr] = hmem_wdata;
      end else if (m_busy && acc_mem_req) begin
        m_q = m_mem[acc_mem_addr];
        if (acc_mem_we) m_mem[acc_mem_addr] = acc_mem_wdata;
      end
      if (hreg_sel && hreg_we && al && idx < N && !m_busy) m_args[idx] = hreg_wdata;
      if (m_busy) begin
        if (acc_done) begin m_busy = 0; m_done = 1; m_res = acc_result; end
      end else if (go) begin
        m_busy = 1; m_done = 0;
      end else if (st_rd) m_done = 0;
      m_start = go;
      m_rdata = nrd;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic [N*DW-1:0] pk;
      for (int i = 0; i < N; i++) pk[i*DW +: DW] = m_args[i];
      check(hmem_ready == !m_busy, "R6 hmem_ready", DW'(hmem_ready), DW'(!m_busy));
      check(acc_owns == m_busy, "R4 acc_owns", DW'(acc_owns), DW'(m_busy));
      check(acc_start == m_start, "R4 acc_start", DW'(acc_start), DW'(m_start));
      check(!(acc_owns && hmem_ready), "R11 mutex", DW'(acc_owns), 0);
      check(acc_args == pk, "R2 acc_args", acc_args[DW-1:0], pk[DW-1:0]);
      check(hreg_rdata == m_rdata, "R10 hreg_rdata", hreg_rdata, m_rdata);
      check(hmem_rdata == m_q, "R10 mem rdata", hmem_rdata, m_q);
    end
  end

  task automatic tick; @(negedge clk); #2; endtask

  task automatic reg_wr(input logic [RAW-1:0] a, input logic [DW-1:0] d);
    hreg_sel = 1; hreg_we = 1; hreg_addr = a; hreg_wdata = d;
    tick;
    hreg_sel = 0; hreg_we = 0;
  endtask

  task automatic reg_rd(input logic [RAW-1:0] a, output logic [DW-1:0] d);
    hreg_sel = 1; hreg_we = 0; hreg_addr = a;
    tick;
    d = hreg_rdata;
    hreg_sel = 0;
  endtask

  task automatic mem_wr(input logic [MAW-1:0] a, input logic [DW-1:0] d);
    hmem_req = 1; hmem_we = 1; hmem_addr = a; hmem_wdata = d;
    while (!hmem_ready) tick;
    tick;
    hmem_req = 0; hmem_we = 0;
  endtask

  task automatic mem_rd(input logic [MAW-1:0] a, output logic [DW-1:0] d);
    hmem_req = 1; hmem_we = 0; hmem_addr = a;
    while (!hmem_ready) tick;
    tick;
    d = hmem_rdata;
    hmem_req = 0;
  endtask

  task automatic acc_wr(input logic [MAW-1:0] a, input logic [DW-1:0] d);
    acc_mem_req = 1; acc_mem_we = 1; acc_mem_addr = a; acc_mem_wdata = d;
    tick;
    acc_mem_req = 0; acc_mem_we = 0;
  endtask

  task automatic acc_rd(input logic [MAW-1:0] a, output logic [DW-1:0] d);
    acc_mem_req = 1; acc_mem_we = 0; acc_mem_addr = a;
    tick;
    d = acc_mem_rdata;
    acc_mem_req = 0;
  endtask

  task automatic acc_finish(input logic [DW-1:0] r);
    acc_done = 1; acc_result = r;
    tick;
    acc_done = 0;
  endtask

  task automatic summary;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      summary();
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (4) @(negedge clk);
    #2; rst = 0;
    tick;
    // R1 reset state
    check(hmem_ready == 1, "R1 ready", DW'(hmem_ready), 1);
    check(acc_owns == 0, "R1 owns", DW'(acc_owns), 0);
    check(acc_start == 0, "R1 start", DW'(acc_start), 0);
    check(acc_args == '0, "R1 args", acc_args[DW-1:0], 0);
    reg_rd(A_STAT, v); check(v == 0, "R1 status", v, 0);

    // R2 argument load and readback
    for (int i = 0; i < N; i++) reg_wr(RAW'(i*4), 32'h1000 + DW'(i));
    reg_rd(6'h0C, v); check(v == 32'h1003, "R2 arg3 readback", v, 32'h1003);
    check(acc_args[7*DW +: DW] == 32'h1007, "R2 arg7 output", acc_args[7*DW +: DW], 32'h1007);

    // R10 unmapped and misaligned reads, memory read latency
    reg_rd(6'h2C, v); check(v == 0, "R10 unmapped", v, 0);
    reg_rd(6'h01, v); check(v == 0, "R10 misaligned", v, 0);
    mem_wr(8'd5, 32'h55); mem_rd(8'd5, v); check(v == 32'h55, "R10 mem read", v, 32'h55);

    // R7 accelerator write while idle is ignored
    acc_wr(8'd20, 32'hFF); mem_rd(8'd20, v); check(v == 0, "R7 idle acc write", v, 0);

    // R4 launch
    reg_wr(A_CTRL, 32'h1);
    check(acc_start == 1, "R4 start pulse", DW'(acc_start), 1);
    check(acc_owns == 1, "R4 owns", DW'(acc_owns), 1);
    check(hmem_ready == 0, "R4 ready low", DW'(hmem_ready), 0);
    tick; check(acc_start == 0, "R4 pulse width", DW'(acc_start), 0);

    // R3 argument write while busy is dropped
    reg_wr(6'h00, 32'hDEAD);
    reg_rd(6'h00, v); check(v == 32'h1000, "R3 arg frozen", v, 32'h1000);
    // R5 relaunch ignored
    reg_wr(A_CTRL, 32'h1); check(acc_start == 0, "R5 no relaunch", DW'(acc_start), 0);
    reg_rd(A_STAT, v); check(v == 1, "R9 busy status", v, 1);

    // R6 stalled host write across accelerator work and completion
    fork
      mem_wr(8'd7, 32'hA5A5);
      begin
        tick;
        check(hmem_ready == 0, "R6 stalled", DW'(hmem_ready), 0);
        acc_wr(8'd9, 32'h1234);
        acc_rd(8'd5, v); check(v == 32'h55, "R7 acc read", v, 32'h55);
        acc_finish(32'hBEEF);
        check(hmem_ready == 1, "R8 ready back", DW'(hmem_ready), 1);
      end
    join
    mem_rd(8'd7, v); check(v == 32'hA5A5, "R6 delayed write kept", v, 32'hA5A5);
    mem_rd(8'd9, v); check(v == 32'h1234, "R7 acc data visible", v, 32'h1234);
    reg_rd(A_RES, v); check(v == 32'hBEEF, "R8 result", v, 32'hBEEF);

    // R9 done sticky, cleared by status read
    reg_rd(A_STAT, v); check(v == 2, "R9 done set", v, 2);
    reg_rd(A_STAT, v); check(v == 0, "R9 done cleared", v, 0);

    // R9 done cleared by next launch
    reg_wr(A_CTRL, 32'h1); tick; acc_finish(32'h77);
    repeat (2) tick;
    reg_wr(A_CTRL, 32'h3);
    reg_rd(A_STAT, v); check(v == 1, "R9 launch clears done", v, 1);
    acc_finish(32'h88);
    reg_rd(A_RES, v); check(v == 32'h88, "R8 second result", v, 32'h88);
    reg_rd(A_STAT, v); check(v == 2, "R9 done after job", v, 2);

    // R7 late accelerator request after release is ignored
    acc_wr(8'd9, 32'h9999); mem_rd(8'd9, v); check(v == 32'h1234, "R7 post-release write", v, 32'h1234);

    repeat (3) tick;
    summary();
  end
endmodule